// File: doc/BRIEF.md
# Selectable Machine-Cycle Rate Generator

This block derives the machine-cycle timing of a small processor subsystem from its input clock. It produces a one-clock-wide enable pulse once per machine cycle. The length of that cycle is set by a two-bit rate field taken from the power control register, which offers 4, 64 or 1024 input clocks per cycle. The core and the clocked peripherals all qualify their flops with these pulses. A slower setting therefore cuts switching activity everywhere, and no clock is stopped.

A second output, the peripheral enable, follows the core enable during normal running. When the idle indicator is high, the core enable is held low, because the core is halted. The peripheral enable then switches to a fixed pulse every 4 clocks, so that timers and the watchdog keep running at a known rate whatever divide setting is in force. One 10-bit counter produces both pulses. The counter wraps at every machine-cycle boundary, and a rate change is only taken up at such a boundary.

Top module: `mcycle_rate_gen`

## Requirements
- R1: While `rstN` is low, both enables are low. Reset selects the 4-clock rate. The counter is aligned so that, when `rstN` is released between two rising edges, `coreEn` is first high in the cycle that follows the third rising edge after the release. The next pulse comes 4 clocks later.
- R2: With `rateSel` = 2'b01 (`rateSel[1]` is register bit 7, `rateSel[0]` is register bit 6) and `idle` low, `coreEn` is high for exactly one clock in every 4.
- R3: With `rateSel` = 2'b10 and `idle` low, consecutive `coreEn` pulses are 64 clocks apart.
- R4: With `rateSel` = 2'b11 and `idle` low, consecutive `coreEn` pulses are 1024 clocks apart.
- R5: The code 2'b00 is reserved. While `rateSel` holds 2'b00, the setting already in force (or the reset setting) stays in force.
- R6: A new `rateSel` value takes effect only at the next machine-cycle boundary. The cycle in progress completes at its old length, and the cycle after it has the new length.
- R7: While `idle` is low, `perEn` equals `coreEn` on every clock.
- R8: While `idle` is high, `coreEn` is low and `perEn` pulses once every 4 clocks, whatever the rate. Idle does not disturb the machine-cycle counter, so when `idle` is lowered, `coreEn` resumes on the same boundary grid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Active-low synchronous reset |
| rateSel | input | 2 | Clock-divide field: 01 = 4, 10 = 64, 11 = 1024 clocks per cycle, 00 reserved |
| idle | input | 1 | High while the core is halted in idle |
| coreEn | output | 1 | One-clock machine-cycle enable for the core |
| perEn | output | 1 | One-clock enable for the clocked peripherals |

## Verification
A vector table steps through each legal code, with the idle indicator both low and high. For each entry it measures the distance between two pulses after alignment, so that a wrong terminal count for any one code is caught separately. Entries that hold the reserved code after a slow or a fast code show whether 00 loads anything. Idle entries with the slow code in force show whether the peripheral rate truly drops back to divide-by-4 rather than following the field. Directed sequences change the code partway through a cycle in both directions, so that the distance to the next pulse shows whether the change waited for the boundary. Other sequences release idle and reset in the middle of a run, to check that the grid is kept across idle and that the first-pulse timing holds after reset.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

  // Rate field as seen by the generator; bit 1 is the upper register bit.
  typedef enum logic [1:0] {
    RATE_RSVD = 2'b00,
    RATE_FAST = 2'b01,
    RATE_MID  = 2'b10,
    RATE_SLOW = 2'b11
  } rateCode_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic clear;     // restart the cycle counter
    logic loadCode;  // capture the requested rate
  } mcrStrobe_t;

  // Status from datapath to control.
  typedef struct packed {
    logic atLast;     // counter sits on the final count of the cycle
    logic atIdleLast; // counter sits on the final count of an idle sub-period
  } mcrStatus_t;

endpackage

// File: rtl/mcr_period_decode.sv
module mcr_period_decode
  import mcr_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int DIV_FAST = 4,
  parameter int DIV_MID  = 64,
  parameter int DIV_SLOW = 1024
) (
  input  rateCode_t          code,
  output logic [CNT_W-1:0]   lastCount
);

  localparam logic [CNT_W-1:0] LAST_FAST = CNT_W'(DIV_FAST - 1);
  localparam logic [CNT_W-1:0] LAST_MID  = CNT_W'(DIV_MID - 1);
  localparam logic [CNT_W-1:0] LAST_SLOW = CNT_W'(DIV_SLOW - 1);

  always_comb begin
    unique case (code)
      RATE_MID:  lastCount = LAST_MID;
      RATE_SLOW: lastCount = LAST_SLOW;
      default:   lastCount = LAST_FAST;
    endcase
  end

endmodule

// File: rtl/mcr_datapath.sv
module mcr_datapath
  import mcr_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int DIV_FAST = 4,
  parameter int DIV_MID  = 64,
  parameter int DIV_SLOW = 1024,
  parameter int IDLE_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  rateCode_t  rateReq,
  input  mcrStrobe_t strobe,
  output mcrStatus_t status
);

  localparam int              IDLE_W   = $clog2(IDLE_DIV);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(IDLE_DIV - 1);

  logic [CNT_W-1:0] cycleCnt;
  logic [CNT_W-1:0] lastCount;
  rateCode_t        activeCode;

  mcr_period_decode #(
    .CNT_W   (CNT_W),
    .DIV_FAST(DIV_FAST),
    .DIV_MID (DIV_MID),
    .DIV_SLOW(DIV_SLOW)
  ) uDecode (
    .code     (activeCode),
    .lastCount(lastCount)
  );

  // Cycle counter: restarts at every boundary.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycleCnt <= '0;
    end else if (strobe.clear) begin
      cycleCnt <= '0;
    end else begin
      cycleCnt <= cycleCnt + CNT_ONE;
    end
  end

  // Rate in force: reset to the fast rate, reloaded only at a boundary.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeCode <= RATE_FAST;
    end else if (strobe.loadCode) begin
      activeCode <= rateReq;
    end
  end

  always_comb begin
    status.atLast     = (cycleCnt == lastCount);
    status.atIdleLast = (cycleCnt[IDLE_W-1:0] == IDLE_LAST);
  end

  // R1: the counter never runs past the final count of the active rate
  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    cycleCnt <= lastCount);

  // R2: after the final count the counter restarts from zero
  a_r2_wrap_zero: assert property (@(posedge clk) disable iff (!rstN)
    status.atLast |=> (cycleCnt == '0));

  // R6: the active rate cannot change away from a boundary
  a_r6_code_hold: assert property (@(posedge clk) disable iff (!rstN)
    !status.atLast |=> $stable(activeCode));

  // R5: the reserved code never becomes the active rate
  a_r5_code_legal: assert property (@(posedge clk) disable iff (!rstN)
    activeCode != RATE_RSVD);

endmodule

// File: rtl/mcr_control.sv
module mcr_control
  import mcr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  rateCode_t  rateReq,
  input  logic       idle,
  input  mcrStatus_t status,
  output mcrStrobe_t strobe,
  output logic       coreEn,
  output logic       perEn
);

  logic boundary;
  logic reqValid;

  always_comb begin
    boundary        = status.atLast;
    reqValid        = (rateReq != RATE_RSVD);
    strobe.clear    = boundary;
    strobe.loadCode = boundary && reqValid;
    coreEn          = rstN && boundary && !idle;
    perEn           = rstN && (idle ? status.atIdleLast : boundary);
  end

  // R2: the core enable is one clock wide
  a_r2_core_single: assert property (@(posedge clk) disable iff (!rstN)
    coreEn |=> !coreEn);

  // R8: the peripheral enable is one clock wide in every mode
  a_r8_per_single: assert property (@(posedge clk) disable iff (!rstN)
    perEn |=> !perEn);

  // R8: the core stays halted while idle
  a_r8_idle_core_off: assert property (@(posedge clk) disable iff (!rstN)
    idle |-> !coreEn);

  // R7: outside idle the peripherals share the core rate
  a_r7_per_tracks: assert property (@(posedge clk) disable iff (!rstN)
    !idle |-> (perEn == coreEn));

endmodule

// File: rtl/mcycle_rate_gen.sv
module mcycle_rate_gen
  import mcr_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int DIV_FAST = 4,
  parameter int DIV_MID  = 64,
  parameter int DIV_SLOW = 1024,
  parameter int IDLE_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] rateSel,
  input  logic       idle,
  output logic       coreEn,
  output logic       perEn
);

  rateCode_t  rateReq;
  mcrStrobe_t strobe;
  mcrStatus_t status;

  assign rateReq = rateCode_t'(rateSel);

  mcr_datapath #(
    .CNT_W   (CNT_W),
    .DIV_FAST(DIV_FAST),
    .DIV_MID (DIV_MID),
    .DIV_SLOW(DIV_SLOW),
    .IDLE_DIV(IDLE_DIV)
  ) uPath (
    .clk    (clk),
    .rstN   (rstN),
    .rateReq(rateReq),
    .strobe (strobe),
    .status (status)
  );

  mcr_control uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .rateReq(rateReq),
    .idle   (idle),
    .status (status),
    .strobe (strobe),
    .coreEn (coreEn),
    .perEn  (perEn)
  );

endmodule

// File: tb/tb_mcycle_rate_gen.sv
module tb_mcycle_rate_gen;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  sel;
    logic        idl;
    logic [11:0] gap;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{2'b01, 1'b0, 12'd4,    4'd2},
    '{2'b10, 1'b0, 12'd64,   4'd3},
    '{2'b11, 1'b0, 12'd1024, 4'd4},
    '{2'b00, 1'b0, 12'd1024, 4'd5},
    '{2'b01, 1'b0, 12'd4,    4'd2},
    '{2'b00, 1'b0, 12'd4,    4'd5},
    '{2'b01, 1'b1, 12'd4,    4'd8},
    '{2'b11, 1'b1, 12'd4,    4'd8},
    '{2'b11, 1'b0, 12'd1024, 4'd4},
    '{2'b10, 1'b0, 12'd64,   4'd3}
  };

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] rateSel;
  logic       idle;
  logic       coreEn;
  logic       perEn;

  int errors = 0;
  int checks = 0;

  mcycle_rate_gen dut (
    .clk    (clk),
    .rstN   (rstN),
    .rateSel(rateSel),
    .idle   (idle),
    .coreEn (coreEn),
    .perEn  (perEn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string reqName(input logic [3:0] r);
    case (r)
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd8:    return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Counts falling edges until the chosen enable is seen high.
  task automatic waitPulse(input bit usePer, output int gap,
                           output int mism, output int coreSeen);
    gap = 0; mism = 0; coreSeen = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      gap++;
      if (perEn != coreEn) mism++;
      if (coreEn) coreSeen++;
      if (usePer ? perEn : coreEn) break;
    end
  endtask

  task automatic resetAndRelease();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(!coreEn && !perEn, "R1", "enables during reset", {coreEn, perEn}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!coreEn, "R1", "no pulse after 1st edge", coreEn, 0);
    @(negedge clk);
    check(!coreEn, "R1", "no pulse after 2nd edge", coreEn, 0);
    @(negedge clk);
    check(coreEn, "R1", "first pulse after 3rd edge", coreEn, 1);
  endtask

  initial begin
    int gap, mism, seen;
    rstN = 1'b0; rateSel = 2'b00; idle = 1'b0;
    @(negedge clk);

    // R1 reset state and first pulse, reserved code held at the input
    resetAndRelease();
    waitPulse(1'b0, gap, mism, seen);
    check(gap == 4, "R1", "default period after reset", gap, 4);

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      rateSel = VECS[v].sel;
      idle    = VECS[v].idl;
      waitPulse(VECS[v].idl, gap, mism, seen);
      waitPulse(VECS[v].idl, gap, mism, seen);
      check(gap == int'(VECS[v].gap), reqName(VECS[v].req), "pulse spacing",
            gap, int'(VECS[v].gap));
      if (VECS[v].idl) begin
        check(seen == 0, "R8", "core enable while idle", seen, 0);
      end else begin
        check(mism == 0, "R7", "perEn differs from coreEn", mism, 0);
      end
    end

    // R6: fast to slow, change requested partway through a cycle
    rateSel = 2'b01;
    waitPulse(1'b0, gap, mism, seen);
    repeat (2) @(negedge clk);
    rateSel = 2'b11;
    waitPulse(1'b0, gap, mism, seen);
    check(gap == 2, "R6", "old fast cycle completes", gap, 2);
    waitPulse(1'b0, gap, mism, seen);
    check(gap == 1024, "R6", "slow rate after boundary", gap, 1024);

    // R6: slow to fast, change requested partway through a cycle
    repeat (10) @(negedge clk);
    rateSel = 2'b01;
    waitPulse(1'b0, gap, mism, seen);
    check(gap == 1014, "R6", "old slow cycle completes", gap, 1014);
    waitPulse(1'b0, gap, mism, seen);
    check(gap == 4, "R6", "fast rate after boundary", gap, 4);

    // R8: idle then resume on the same grid
    idle = 1'b1;
    waitPulse(1'b1, gap, mism, seen);
    check(gap == 4, "R8", "idle peripheral pulse on grid", gap, 4);
    idle = 1'b0;
    waitPulse(1'b0, gap, mism, seen);
    check(gap == 4, "R8", "core resumes on grid", gap, 4);

    // R1/R5: reset in the middle of a slow run, reserved code at input
    rateSel = 2'b11;
    waitPulse(1'b0, gap, mism, seen);
    repeat (100) @(negedge clk);
    rateSel = 2'b00;
    resetAndRelease();
    waitPulse(1'b0, gap, mism, seen);
    check(gap == 4, "R5", "reset rate kept under reserved code", gap, 4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule